// File: doc/BRIEF.md
# Single-Cycle Byte Stack Processor Core

This block is a compact stack machine for control tasks inside a larger chip. Its data path is 8 bits wide and its instructions are 9 bits wide. Every instruction retires in one clock. The operand stack is split into a top register and a second register, with the deeper entries kept in a separate array. A second array holds return addresses, and it can also hold bytes that software parks there. The core also has a program counter, an instruction memory that a loading port fills, and up to four byte-wide data banks.

An instruction with bit 8 clear pushes its low byte as a literal. An instruction with bit 8 set is an operation, and bits 7:5 give its class. Class `000` is the ALU, stack, return and port group, and bits 4:0 select the function. Class `001` is data memory: bit 4 selects store (1) or fetch (0), bits 3:2 select the address mode (1 = post-increment, 2 = post-decrement, 0 or 3 = unchanged), and bits 1:0 give the bank. Classes `010` and `011` do nothing. When bit 7 is set the instruction is a branch. Bits 6:5 give its kind (0 jump, 1 conditional jump, 2 call, 3 conditional call), and bits 4:0 supply the upper target bits. The low eight target bits are taken from the top of the stack, which the previous instruction pushed.

Top module: `stk8_core`

## Requirements
- R1: While `rst` is high, `io_wr_stb` stays low. One clock after `rst` is seen high, `pc_o` is 0. Reset is synchronous and active-high.
- R2: An instruction with bit 8 = 0 pushes bits 7:0. The old top moves to second place and the old second entry moves into the deeper stack.
- R3: Function codes 1 (add: second+top), 2 (sub: second−top), 3 (inc) and 4 (dec) wrap modulo 256. Add and sub pop one entry.
- R4: Codes 5 (and), 6 (or) and 7 (xor) combine second with top and pop one entry.
- R5: The shift codes change only the top. 8: left, insert 0. 9: left, insert 1. 10: right, insert 0. 11: right, insert 1. 12: left, insert old msb. 13: right, keep msb. 14: right, insert old lsb.
- R6: The test codes replace the top with 0xFF when the condition holds and with 0x00 when it does not. 15: top = 0. 16: top ≠ 0. 17: top = 0xFF. 18: top ≠ 0xFF.
- R7: The stack codes are 19 drop, 20 dup, 21 nip, 22 over and 23 swap.
- R8: Code 24 moves the top onto the return stack. Code 25 moves the newest return entry onto the data stack. Code 26 copies that entry without popping it.
- R9: A fetch replaces the top address with the byte at that address in the selected bank. A fetch with post-increment or post-decrement keeps the adjusted address on top, with the fetched byte beneath it. A store writes second to bank[top]. A plain store pops both; an adjusting store leaves the adjusted address on top. Each bank is separate from the others.
- R10: A jump loads the program counter with {bits 4:0, top}, truncated to the program-counter width, and pops the address byte.
- R11: A conditional jump or call takes the branch only when second is nonzero. Taken or not, it pops both the address byte and the condition.
- R12: A call pushes its own address plus one onto the return stack. Code 29 pops the return stack into the program counter.
- R13: Code 28 raises `io_wr_stb` for one cycle, with `io_addr` = top and `io_wdata` = second, and then pops the address. Code 27 replaces the top with `io_rdata`, which is read from port `io_addr` = top.
- R14: A loading-port write with `ld_we` high stores `ld_data` at `ld_addr`, and the core executes it when the program counter reaches that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Instruction memory write enable |
| ld_addr | input | PC_W | Instruction memory write address |
| ld_data | input | 9 | Instruction word to store |
| io_rdata | input | 8 | Read data from the addressed input port |
| io_addr | output | 8 | Port address (current top of stack) |
| io_wdata | output | 8 | Output port data (current second entry) |
| io_wr_stb | output | 1 | One-cycle output port write strobe |
| pc_o | output | PC_W | Current program counter |

## Verification
A wrong stack pointer or a corrupted top or second register appears on the port interface only when the program next writes to an output port. For that reason every test program ends by draining its stack, one entry per output write, and a single misplaced byte shows up as a wrong value or a wrong order in that drained sequence. A wrong branch target or a lost return address becomes visible sooner. Either a marker byte that should have been skipped is written, or an expected write never comes, within a few cycles of the bad transfer. The count of writes catches both cases.

// File: rtl/stk8_pkg.sv
package stk8_pkg;
    localparam int DATA_W  = 8;
    localparam int INSTR_W = 9;

    typedef enum logic [4:0] {
        F_NOP   = 5'd0,  F_ADD   = 5'd1,  F_SUB   = 5'd2,  F_INC   = 5'd3,
        F_DEC   = 5'd4,  F_AND   = 5'd5,  F_OR    = 5'd6,  F_XOR   = 5'd7,
        F_SHL0  = 5'd8,  F_SHL1  = 5'd9,  F_SHR0  = 5'd10, F_SHR1  = 5'd11,
        F_ROTL  = 5'd12, F_ASR   = 5'd13, F_ROTR  = 5'd14, F_EQZ   = 5'd15,
        F_NEZ   = 5'd16, F_EQF   = 5'd17, F_NEF   = 5'd18, F_DROP  = 5'd19,
        F_DUP   = 5'd20, F_NIP   = 5'd21, F_OVER  = 5'd22, F_SWAP  = 5'd23,
        F_TOR   = 5'd24, F_FROMR = 5'd25, F_RCOPY = 5'd26, F_IN    = 5'd27,
        F_OUT   = 5'd28, F_RET   = 5'd29, F_SP30  = 5'd30, F_SP31  = 5'd31
    } func_e;

    typedef enum logic [1:0] {
        BR_JUMP  = 2'd0,
        BR_JUMPC = 2'd1,
        BR_CALL  = 2'd2,
        BR_CALLC = 2'd3
    } branch_e;
endpackage

// File: rtl/stk8_alu.sv
module stk8_alu
    import stk8_pkg::*;
(
    input  func_e             func,
    input  logic [DATA_W-1:0] top,
    input  logic [DATA_W-1:0] sec,
    output logic [DATA_W-1:0] res
);
    localparam logic [DATA_W-1:0] ONES = '1;

    always_comb begin
        res = top;
        unique case (func)
            F_ADD:   res = sec + top;
            F_SUB:   res = sec - top;
            F_INC:   res = top + 1'b1;
            F_DEC:   res = top - 1'b1;
            F_AND:   res = sec & top;
            F_OR:    res = sec | top;
            F_XOR:   res = sec ^ top;
            F_SHL0:  res = {top[DATA_W-2:0], 1'b0};
            F_SHL1:  res = {top[DATA_W-2:0], 1'b1};
            F_SHR0:  res = {1'b0, top[DATA_W-1:1]};
            F_SHR1:  res = {1'b1, top[DATA_W-1:1]};
            F_ROTL:  res = {top[DATA_W-2:0], top[DATA_W-1]};
            F_ASR:   res = {top[DATA_W-1], top[DATA_W-1:1]};
            F_ROTR:  res = {top[0], top[DATA_W-1:1]};
            F_EQZ:   res = (top == '0)   ? ONES : '0;
            F_NEZ:   res = (top != '0)   ? ONES : '0;
            F_EQF:   res = (top == ONES) ? ONES : '0;
            F_NEF:   res = (top != ONES) ? ONES : '0;
            default: res = top;
        endcase
    end

    // a_r6_test_is_mask: test results are all-zeros or all-ones
    always_comb begin
        if (func inside {F_EQZ, F_NEZ, F_EQF, F_NEF}) begin
            a_r6_test_is_mask: assert (res == '0 || res == ONES);
        end
    end
endmodule

// File: rtl/stk8_lifo.sv
module stk8_lifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop1,
    input  logic         pop2,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rd1,
    output logic [W-1:0] rd2
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  store_q [DEPTH];
    logic [PW-1:0] ptr_q, ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (push)      ptr_d = ptr_q + PW'(1);
        else if (pop2) ptr_d = ptr_q - PW'(2);
        else if (pop1) ptr_d = ptr_q - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) store_q[ptr_q] <= wdata;
    end

    assign rd1 = store_q[ptr_q - PW'(1)];
    assign rd2 = store_q[ptr_q - PW'(2)];

    // a_r7_push_step: a push advances the pointer by exactly one
    a_r7_push_step: assert property (@(posedge clk) disable iff (rst)
        push |=> ptr_q == $past(ptr_q) + PW'(1));
    // a_r11_pop_two: a double pop retreats the pointer by two
    a_r11_pop_two: assert property (@(posedge clk) disable iff (rst)
        (pop2 && !push) |=> ptr_q == $past(ptr_q) - PW'(2));
endmodule

// File: rtl/stk8_dmem.sv
module stk8_dmem #(
    parameter int BANKS = 4,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [1:0]    bank,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int WORDS = 1 << AW;

    logic [7:0] bank_rd [4];

    for (genvar b = 0; b < 4; b++) begin : g_bank
        if (b < BANKS) begin : g_mem
            logic [7:0] cells_q [WORDS];
            always_ff @(posedge clk) begin
                if (we && bank == 2'(b)) cells_q[addr] <= wdata;
            end
            assign bank_rd[b] = cells_q[addr];
        end else begin : g_none
            assign bank_rd[b] = '0;
        end
    end

    assign rdata = bank_rd[bank];
endmodule

// File: rtl/stk8_core.sv
module stk8_core
    import stk8_pkg::*;
#(
    parameter int PC_W     = 10,
    parameter int DS_DEPTH = 128,
    parameter int RS_DEPTH = 32,
    parameter int BANKS    = 4,
    parameter int MEM_AW   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_we,
    input  logic [PC_W-1:0]     ld_addr,
    input  logic [INSTR_W-1:0]  ld_data,
    input  logic [DATA_W-1:0]   io_rdata,
    output logic [DATA_W-1:0]   io_addr,
    output logic [DATA_W-1:0]   io_wdata,
    output logic                io_wr_stb,
    output logic [PC_W-1:0]     pc_o
);
    localparam int IMEM_WORDS = 1 << PC_W;
    localparam int HI_W       = PC_W - DATA_W;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] t;
        logic [DATA_W-1:0] n;
    } core_s;

    core_s cur_q, nxt_d;

    logic [INSTR_W-1:0] imem_q [IMEM_WORDS];
    logic [INSTR_W-1:0] instr;

    logic              ds_push, ds_pop1, ds_pop2;
    logic [DATA_W-1:0] ds_rd1, ds_rd2;
    logic              rs_push, rs_pop;
    logic [PC_W-1:0]   rs_wdata, rs_rd1, rs_rd2;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rd, alu_res, adj_addr;
    logic              wr_cmd;
    logic [PC_W-1:0]   pc_inc, target;
    func_e             func;
    branch_e           bkind;

    always_ff @(posedge clk) begin
        if (ld_we) imem_q[ld_addr] <= ld_data;
    end
    assign instr = imem_q[cur_q.pc];

    assign func     = func_e'(instr[4:0]);
    assign bkind    = branch_e'(instr[6:5]);
    assign pc_inc   = cur_q.pc + PC_W'(1);
    assign target   = {instr[HI_W-1:0], cur_q.t};
    assign adj_addr = (instr[3:2] == 2'd1) ? cur_q.t + 1'b1 : cur_q.t - 1'b1;

    stk8_alu u_alu (
        .func (func),
        .top  (cur_q.t),
        .sec  (cur_q.n),
        .res  (alu_res)
    );

    stk8_lifo #(.DEPTH(DS_DEPTH), .W(DATA_W)) u_dstack (
        .clk   (clk),
        .rst   (rst),
        .push  (ds_push),
        .pop1  (ds_pop1),
        .pop2  (ds_pop2),
        .wdata (cur_q.n),
        .rd1   (ds_rd1),
        .rd2   (ds_rd2)
    );

    stk8_lifo #(.DEPTH(RS_DEPTH), .W(PC_W)) u_rstack (
        .clk   (clk),
        .rst   (rst),
        .push  (rs_push),
        .pop1  (rs_pop),
        .pop2  (1'b0),
        .wdata (rs_wdata),
        .rd1   (rs_rd1),
        .rd2   (rs_rd2)
    );

    stk8_dmem #(.BANKS(BANKS), .AW(MEM_AW)) u_dmem (
        .clk   (clk),
        .we    (mem_we),
        .bank  (instr[1:0]),
        .addr  (cur_q.t[MEM_AW-1:0]),
        .wdata (cur_q.n),
        .rdata (mem_rd)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.pc = pc_inc;
        ds_push  = 1'b0;
        ds_pop1  = 1'b0;
        ds_pop2  = 1'b0;
        rs_push  = 1'b0;
        rs_pop   = 1'b0;
        rs_wdata = pc_inc;
        mem_we   = 1'b0;
        wr_cmd   = 1'b0;
        if (!instr[8]) begin
            ds_push = 1'b1;
            nxt_d.n = cur_q.t;
            nxt_d.t = instr[7:0];
        end else if (instr[7]) begin
            if (bkind == BR_JUMPC || bkind == BR_CALLC) begin
                ds_pop2 = 1'b1;
                nxt_d.t = ds_rd1;
                nxt_d.n = ds_rd2;
                if (cur_q.n != '0) begin
                    nxt_d.pc = target;
                    rs_push  = (bkind == BR_CALLC);
                end
            end else begin
                ds_pop1  = 1'b1;
                nxt_d.t  = cur_q.n;
                nxt_d.n  = ds_rd1;
                nxt_d.pc = target;
                rs_push  = (bkind == BR_CALL);
            end
        end else if (instr[7:5] == 3'b001) begin
            if (instr[4]) begin
                mem_we = 1'b1;
                if (instr[3:2] == 2'd1 || instr[3:2] == 2'd2) begin
                    ds_pop1 = 1'b1;
                    nxt_d.t = adj_addr;
                    nxt_d.n = ds_rd1;
                end else begin
                    ds_pop2 = 1'b1;
                    nxt_d.t = ds_rd1;
                    nxt_d.n = ds_rd2;
                end
            end else if (instr[3:2] == 2'd1 || instr[3:2] == 2'd2) begin
                ds_push = 1'b1;
                nxt_d.n = mem_rd;
                nxt_d.t = adj_addr;
            end else begin
                nxt_d.t = mem_rd;
            end
        end else if (instr[7:5] == 3'b000) begin
            unique case (func)
                F_ADD, F_SUB, F_AND, F_OR, F_XOR: begin
                    ds_pop1 = 1'b1;
                    nxt_d.t = alu_res;
                    nxt_d.n = ds_rd1;
                end
                F_INC, F_DEC, F_SHL0, F_SHL1, F_SHR0, F_SHR1, F_ROTL,
                F_ASR, F_ROTR, F_EQZ, F_NEZ, F_EQF, F_NEF: begin
                    nxt_d.t = alu_res;
                end
                F_DROP, F_OUT: begin
                    ds_pop1 = 1'b1;
                    nxt_d.t = cur_q.n;
                    nxt_d.n = ds_rd1;
                    wr_cmd  = (func == F_OUT);
                end
                F_DUP: begin
                    ds_push = 1'b1;
                    nxt_d.n = cur_q.t;
                end
                F_NIP: begin
                    ds_pop1 = 1'b1;
                    nxt_d.n = ds_rd1;
                end
                F_OVER: begin
                    ds_push = 1'b1;
                    nxt_d.t = cur_q.n;
                    nxt_d.n = cur_q.t;
                end
                F_SWAP: begin
                    nxt_d.t = cur_q.n;
                    nxt_d.n = cur_q.t;
                end
                F_TOR: begin
                    rs_push  = 1'b1;
                    rs_wdata = PC_W'(cur_q.t);
                    ds_pop1  = 1'b1;
                    nxt_d.t  = cur_q.n;
                    nxt_d.n  = ds_rd1;
                end
                F_FROMR, F_RCOPY: begin
                    ds_push = 1'b1;
                    rs_pop  = (func == F_FROMR);
                    nxt_d.n = cur_q.t;
                    nxt_d.t = rs_rd1[DATA_W-1:0];
                end
                F_IN: nxt_d.t = io_rdata;
                F_RET: begin
                    rs_pop   = 1'b1;
                    nxt_d.pc = rs_rd1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.pc <= '0;
            cur_q.t  <= '0;
            cur_q.n  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign io_addr   = cur_q.t;
    assign io_wdata  = cur_q.n;
    assign io_wr_stb = wr_cmd & ~rst;
    assign pc_o      = cur_q.pc;

    // a_r1_quiet_in_reset
    a_r1_quiet_in_reset: assert property (@(posedge clk) rst |-> !io_wr_stb);
    // a_r1_pc_cleared
    a_r1_pc_cleared: assert property (@(posedge clk) rst |=> pc_o == '0);
    // a_r2_literal_on_top
    a_r2_literal_on_top: assert property (@(posedge clk) disable iff (rst)
        !instr[8] |=> cur_q.t == $past(instr[7:0]));
    // a_r10_jump_target
    a_r10_jump_target: assert property (@(posedge clk) disable iff (rst)
        (instr[8:5] == 4'b1100) |=> pc_o == $past({instr[HI_W-1:0], cur_q.t}));
    // a_r11_not_taken
    a_r11_not_taken: assert property (@(posedge clk) disable iff (rst)
        (instr[8:7] == 2'b11 && instr[5] && cur_q.n == '0)
        |=> pc_o == $past(pc_o) + PC_W'(1));
    // a_r12_return_target
    a_r12_return_target: assert property (@(posedge clk) disable iff (rst)
        (instr == {4'b1000, F_RET}) |=> pc_o == $past(rs_rd1));
    // a_r13_strobe_single
    a_r13_strobe_single: assert property (@(posedge clk) disable iff (rst)
        (io_wr_stb && instr[8:5] == 4'b1000 && instr[4:0] == F_OUT)
        |=> cur_q.t == $past(cur_q.n));
endmodule

// File: tb/stk8_core_tb_top.sv
module stk8_core_tb_top;
    localparam int PC_W = 10;

    localparam logic [8:0] OP_DROP = 9'h113, OP_DUP = 9'h114, OP_NIP = 9'h115;
    localparam logic [8:0] OP_OVER = 9'h116, OP_SWAP = 9'h117, OP_TOR = 9'h118;
    localparam logic [8:0] OP_FROMR = 9'h119, OP_RCOPY = 9'h11A, OP_IN = 9'h11B;
    localparam logic [8:0] OP_OUT = 9'h11C, OP_RET = 9'h11D;
    localparam logic [8:0] OP_JMP = 9'h180, OP_JMPC = 9'h1A0;
    localparam logic [8:0] OP_CALL = 9'h1C0, OP_CALLC = 9'h1E0;

    // {opcode, first literal, second literal, expected result}
    localparam logic [32:0] VEC [24] = '{
        {9'h101, 8'h7F, 8'h81, 8'h00}, {9'h101, 8'hFF, 8'h02, 8'h01},
        {9'h102, 8'h03, 8'h05, 8'hFE}, {9'h103, 8'h00, 8'hFF, 8'h00},
        {9'h104, 8'h00, 8'h00, 8'hFF}, {9'h105, 8'hF0, 8'h3C, 8'h30},
        {9'h106, 8'hF0, 8'h0F, 8'hFF}, {9'h107, 8'hAA, 8'hFF, 8'h55},
        {9'h108, 8'h00, 8'h81, 8'h02}, {9'h109, 8'h00, 8'h81, 8'h03},
        {9'h10A, 8'h00, 8'h81, 8'h40}, {9'h10B, 8'h00, 8'h80, 8'hC0},
        {9'h10C, 8'h00, 8'h81, 8'h03}, {9'h10C, 8'h00, 8'h40, 8'h80},
        {9'h10D, 8'h00, 8'h82, 8'hC1}, {9'h10E, 8'h00, 8'h01, 8'h80},
        {9'h10F, 8'h00, 8'h00, 8'hFF}, {9'h10F, 8'h00, 8'h01, 8'h00},
        {9'h110, 8'h00, 8'h00, 8'h00}, {9'h110, 8'h00, 8'h05, 8'hFF},
        {9'h111, 8'h00, 8'hFF, 8'hFF}, {9'h111, 8'h00, 8'hFE, 8'h00},
        {9'h112, 8'h00, 8'hFF, 8'h00}, {9'h112, 8'h00, 8'h00, 8'hFF}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ld_we = 1'b0;
    logic [PC_W-1:0] ld_addr = '0;
    logic [8:0]      ld_data = '0;
    logic [7:0]      io_rdata = 8'h5A;
    logic [7:0]      io_addr, io_wdata;
    logic            io_wr_stb;
    logic [PC_W-1:0] pc_o;

    int checks = 0;
    int errors = 0;
    int lp = 0;
    int log_n = 0;
    logic [7:0] log_d [16];
    logic [7:0] log_a [16];

    always #10 clk = ~clk;

    stk8_core #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .io_rdata(io_rdata), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr_stb(io_wr_stb), .pc_o(pc_o)
    );

    always @(negedge clk) begin
        if (!rst && io_wr_stb && log_n < 16) begin
            log_d[log_n] = io_wdata;
            log_a[log_n] = io_addr;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic emit(input logic [8:0] w);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_addr = PC_W'(lp);
        ld_data = w;
        @(negedge clk);
        ld_we = 1'b0;
        lp++;
    endtask

    task automatic lit(input logic [7:0] v);
        emit({1'b0, v});
    endtask

    task automatic halt();
        lit(8'(lp));
        emit(OP_JMP);
    endtask

    task automatic dump(input int k);
        for (int i = 0; i < k; i++) begin
            lit(8'h20);
            emit(OP_OUT);
            emit(OP_DROP);
        end
    endtask

    task automatic run(input int cyc);
        log_n = 0;
        @(negedge clk);
        rst = 1'b0;
        repeat (cyc) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_seq(input string tag, input int n, input logic [7:0] e0,
                              input logic [7:0] e1, input logic [7:0] e2,
                              input logic [7:0] e3, input logic [7:0] e4,
                              input logic [7:0] e5);
        logic [7:0] ev [6];
        ev = '{e0, e1, e2, e3, e4, e5};
        chk(log_n == n, {tag, " write count"}, log_n, n);
        for (int i = 0; i < n && i < 6; i++)
            chk(log_d[i] == ev[i], tag, log_d[i], ev[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with an output-port instruction at address 0
        lp = 0;
        emit(OP_OUT);
        repeat (3) @(negedge clk);
        chk(pc_o == '0, "R1 pc in reset", pc_o, 0);
        chk(io_wr_stb == 1'b0, "R1 strobe in reset", io_wr_stb, 0);

        // R3 R4 R5 R6 R14: table of one-operation programs
        foreach (VEC[i]) begin
            lp = 0;
            lit(VEC[i][23:16]);
            lit(VEC[i][15:8]);
            emit(VEC[i][32:24]);
            lit(8'h20);
            emit(OP_OUT);
            halt();
            run(12);
            chk(log_n == 1, "R13 one write per vector", log_n, 1);
            chk(log_a[0] == 8'h20, "R13 port address", log_a[0], 8'h20);
            chk(log_d[0] == VEC[i][7:0], "R3/R4/R5/R6 result", log_d[0], VEC[i][7:0]);
        end
        chk(pc_o == '0, "R1 pc after reset", pc_o, 0);

        // R2 R7: literals and stack shuffles
        lp = 0;
        lit(8'h01); lit(8'h02); lit(8'h03);
        emit(OP_OVER); emit(OP_SWAP); emit(OP_NIP); emit(OP_DUP);
        dump(4);
        halt();
        run(30);
        expect_seq("R7 stack ops", 4, 8'h03, 8'h03, 8'h02, 8'h01, 8'h00, 8'h00);

        // R8: return stack transfers
        lp = 0;
        lit(8'h07); emit(OP_TOR); lit(8'h09); emit(OP_RCOPY); emit(OP_FROMR);
        dump(3);
        halt();
        run(25);
        expect_seq("R8 return stack", 3, 8'h07, 8'h07, 8'h09, 8'h00, 8'h00, 8'h00);

        // R9: banks, post-increment fetch, post-decrement store
        lp = 0;
        lit(8'hAA); lit(8'h05); emit(9'h131);
        lit(8'h55); lit(8'h05); emit(9'h132);
        lit(8'h05); emit(9'h121);
        lit(8'h05); emit(9'h122);
        lit(8'h05); emit(9'h125);
        lit(8'h11); lit(8'h10); emit(9'h138);
        lit(8'h10); emit(9'h120);
        dump(6);
        halt();
        run(45);
        expect_seq("R9 memory", 6, 8'h11, 8'h0F, 8'h06, 8'hAA, 8'h55, 8'hAA);

        // R10 R11 R12: jumps, conditional branches, calls and returns
        lp = 0;
        lit(8'h05); emit(OP_JMP); lit(8'hE1); lit(8'h20); emit(OP_OUT);
        lit(8'h00); lit(8'h0A); emit(OP_JMPC);
        lit(8'hB1); lit(8'h20); emit(OP_OUT); emit(OP_DROP);
        lit(8'h01); lit(8'h11); emit(OP_JMPC);
        lit(8'hE2); lit(8'hE2);
        lit(8'h30); emit(OP_CALL | 9'h001);
        lit(8'h00); lit(8'h30); emit(OP_CALLC | 9'h001);
        lit(8'h01); lit(8'h40); emit(OP_CALLC | 9'h001);
        lit(8'hB3); lit(8'h20); emit(OP_OUT); emit(OP_DROP);
        halt();
        lp = 304;
        lit(8'hB2); lit(8'h20); emit(OP_OUT); emit(OP_DROP); emit(OP_RET);
        lp = 320;
        lit(8'hB4); lit(8'h20); emit(OP_OUT); emit(OP_DROP); emit(OP_RET);
        run(80);
        expect_seq("R10/R11/R12 flow", 4, 8'hB1, 8'hB2, 8'hB4, 8'hB3, 8'h00, 8'h00);

        // R13: input port read
        lp = 0;
        io_rdata = 8'h5A;
        lit(8'h40); emit(OP_IN); lit(8'h21); emit(OP_OUT);
        halt();
        run(12);
        expect_seq("R13 input port", 1, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        chk(log_a[0] == 8'h21, "R13 write address", log_a[0], 8'h21);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule